// File: doc/BRIEF.md
# OS Entry Core Assignment Table

When a thread leaves user code for the operating system, this block decides which OS core runs the handler. The choice depends on what is being entered, not on which thread enters it. A lookup is keyed by an entry class and an entry number. The class says whether the entry is a system call, an interrupt or a page fault. For a system call, the number is the call number taken from the agreed global register.

Configuration writes preload a table of keys. Each key carries a mask of the cores allowed to serve that entry. Several keys may name the same core.

A lookup that matches an entry picks the lowest-numbered allowed core that has a free hardware context. A lookup that misses is given one OS core, chosen by a round-robin pointer over the OS partition. That choice is then stored as a new single-core entry, so later lookups for the same key go to the same core.

The result is registered, so it appears one cycle after the request. A configuration write and a lookup can arrive in the same cycle. In that case the write takes the free slot, and the miss is answered but not stored, with the pointer left where it was.

Top module: `os_entry_router`

## Requirements
- R1: After reset `rsp_valid` is low and the table is empty. The first miss then goes to the lowest-numbered core in `os_mask`.
- R2: The key is the pair {class, number}, where class 0 is a system call, 1 is an interrupt and 2 is a page fault. The same number under two classes gives two separate entries.
- R3: On a hit, `rsp_core` is the lowest-numbered core that is set in both the entry mask and `ctx_free`. `rsp_hit` is 1 and `rsp_wait` is 0.
- R4: On a hit where no allowed core is free, `rsp_core` is the lowest-numbered core in the entry mask and `rsp_wait` is 1.
- R5: Different keys may name the same core, and each of them resolves to that core.
- R6: A miss while the table has room returns the first core at or after the pointer that is set in `os_mask`, with `rsp_hit` at 0. It stores that core as a single-core entry and moves the pointer to the next core number. On a miss, `rsp_wait` is the inverse of that core's `ctx_free` bit.
- R7: The pointer skips cores outside `os_mask` and wraps from the highest core number to core 0.
- R8: A miss while all DEPTH entries are in use returns the pointer's core. It stores nothing and leaves the pointer unchanged.
- R9: The response appears on the cycle after `lk_valid`. An entry learned from a miss is matched by a lookup issued in the very next cycle.
- R10: A configuration write to a key already in the table replaces its mask, even when the table is full. A write to a new key is appended while there is room.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| os_mask | input | NCORES | Cores in the OS partition |
| ctx_free | input | NCORES | Cores that have a free hardware context |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_class | input | 2 | Class of the key being written |
| cfg_num | input | NUM_W | Number of the key being written |
| cfg_mask | input | NCORES | Allowed-core mask for that key |
| lk_valid | input | 1 | Lookup request |
| lk_class | input | 2 | Class of the entry being looked up |
| lk_num | input | NUM_W | Call number or handler number |
| rsp_valid | output | 1 | Response valid, one cycle after the request |
| rsp_core | output | log2(NCORES) | Chosen core |
| rsp_hit | output | 1 | The key was found in the table |
| rsp_wait | output | 1 | The chosen core has no free context |

## Verification
The bench builds the block with eight cores, an OS partition of cores 2 to 7, and DEPTH set to 6 rather than 64. The small depth lets a handful of learned call numbers fill the table. That brings the no-store fallback, and a configuration overwrite while full, within reach in a few cycles. Six consecutive misses after a fresh reset walk the pointer across the whole partition, past the two user cores, and wrap it back to core 2.

// File: rtl/os_entry_router.sv
module os_entry_router #(
  parameter int NCORES = 8,
  parameter int NUM_W  = 8,
  parameter int DEPTH  = 64
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NCORES-1:0]        os_mask,
  input  logic [NCORES-1:0]        ctx_free,
  input  logic                     cfg_we,
  input  logic [1:0]               cfg_class,
  input  logic [NUM_W-1:0]         cfg_num,
  input  logic [NCORES-1:0]        cfg_mask,
  input  logic                     lk_valid,
  input  logic [1:0]               lk_class,
  input  logic [NUM_W-1:0]         lk_num,
  output logic                     rsp_valid,
  output logic [$clog2(NCORES)-1:0] rsp_core,
  output logic                     rsp_hit,
  output logic                     rsp_wait
);
  localparam int CORE_W = $clog2(NCORES);
  localparam int KEY_W  = 2 + NUM_W;
  localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int FILL_W = $clog2(DEPTH + 1);

  logic [KEY_W-1:0]  key_q  [DEPTH];
  logic [NCORES-1:0] mask_q [DEPTH];
  logic [FILL_W-1:0] fill;
  logic [CORE_W-1:0] rr;

  wire [KEY_W-1:0] lk_key  = {lk_class, lk_num};
  wire [KEY_W-1:0] cfg_key = {cfg_class, cfg_num};
  wire             room    = fill < FILL_W'(DEPTH);

  logic              lk_hit, cfg_hit, rr_found;
  logic [NCORES-1:0] lk_mask;
  logic [IDX_W-1:0]  cfg_idx;
  logic [CORE_W-1:0] rr_core;

  function automatic logic [CORE_W-1:0] lowest(input logic [NCORES-1:0] m);
    lowest = '0;
    for (int b = NCORES - 1; b >= 0; b--)
      if (m[b]) lowest = CORE_W'(b);
  endfunction

  always_comb begin
    lk_hit  = 1'b0;
    lk_mask = '0;
    cfg_hit = 1'b0;
    cfg_idx = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (FILL_W'(i) < fill && key_q[i] == lk_key) begin
        lk_hit  = 1'b1;
        lk_mask = mask_q[i];
      end
      if (FILL_W'(i) < fill && key_q[i] == cfg_key) begin
        cfg_hit = 1'b1;
        cfg_idx = IDX_W'(i);
      end
    end
  end

  always_comb begin
    rr_core  = '0;
    rr_found = 1'b0;
    for (int k = 0; k < NCORES; k++) begin
      int j;
      j = int'(rr) + k;
      if (j >= NCORES) j = j - NCORES;
      if (!rr_found && os_mask[j]) begin
        rr_found = 1'b1;
        rr_core  = CORE_W'(j);
      end
    end
  end

  wire [NCORES-1:0] sel_free = lk_mask & ctx_free;
  wire [CORE_W-1:0] hit_core = (|sel_free) ? lowest(sel_free) : lowest(lk_mask);
  wire              learn    = lk_valid && !lk_hit && !cfg_we && room && rr_found;
  wire              cfg_wr   = cfg_we && (cfg_hit || room);
  wire [IDX_W-1:0]  cfg_slot = cfg_hit ? cfg_idx : fill[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (cfg_wr) begin
      key_q[cfg_slot]  <= cfg_key;
      mask_q[cfg_slot] <= cfg_mask;
    end else if (learn) begin
      key_q[fill[IDX_W-1:0]]  <= lk_key;
      mask_q[fill[IDX_W-1:0]] <= NCORES'(1) << rr_core;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fill      <= '0;
      rr        <= '0;
      rsp_valid <= 1'b0;
      rsp_core  <= '0;
      rsp_hit   <= 1'b0;
      rsp_wait  <= 1'b0;
    end else begin
      if (cfg_wr && !cfg_hit) fill <= fill + 1'b1;
      else if (learn) begin
        fill <= fill + 1'b1;
        rr   <= (rr_core == CORE_W'(NCORES - 1)) ? '0 : rr_core + 1'b1;
      end
      rsp_valid <= lk_valid;
      if (lk_valid) begin
        rsp_hit  <= lk_hit;
        rsp_core <= lk_hit ? hit_core : rr_core;
        rsp_wait <= lk_hit ? !(|sel_free) : !ctx_free[rr_core];
      end
    end
  end

  assert_rsp_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rsp_valid);
  assert_rsp_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !rsp_valid);
  assert_free_core_R3: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid && lk_hit |=> rsp_wait || ((($past(ctx_free) >> rsp_core) & NCORES'(1)) != '0));
  assert_wait_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> !rsp_wait || ((($past(ctx_free) >> rsp_core) & NCORES'(1)) == '0));
  assert_miss_os_R6: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid && !lk_hit |=> ((os_mask >> rsp_core) & NCORES'(1)) != '0 || $past(os_mask) == '0);
  assert_ptr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !learn |=> $stable(rr));
  assert_fill_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= FILL_W'(DEPTH));
endmodule

// File: tb/tb_os_entry_router.sv
module tb_os_entry_router;
  localparam int NCORES = 8;
  localparam int NUM_W  = 8;
  localparam int DEPTH  = 6;
  localparam int NV     = 13;

  logic clk = 0;
  logic rst_n;
  logic [NCORES-1:0] os_mask = 8'hFC;
  logic [NCORES-1:0] ctx_free = 8'hFF;
  logic cfg_we = 0;
  logic [1:0] cfg_class = 0;
  logic [NUM_W-1:0] cfg_num = 0;
  logic [NCORES-1:0] cfg_mask = 0;
  logic lk_valid = 0;
  logic [1:0] lk_class = 0;
  logic [NUM_W-1:0] lk_num = 0;
  logic rsp_valid, rsp_hit, rsp_wait;
  logic [2:0] rsp_core;

  int tests = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  os_entry_router #(.NCORES(NCORES), .NUM_W(NUM_W), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .os_mask(os_mask), .ctx_free(ctx_free),
    .cfg_we(cfg_we), .cfg_class(cfg_class), .cfg_num(cfg_num), .cfg_mask(cfg_mask),
    .lk_valid(lk_valid), .lk_class(lk_class), .lk_num(lk_num),
    .rsp_valid(rsp_valid), .rsp_core(rsp_core), .rsp_hit(rsp_hit), .rsp_wait(rsp_wait));

  // {class, num, ctx_free, core, hit, wait}
  localparam logic [22:0] VEC [NV] = '{
    {2'd0, 8'd5,  8'hFF, 3'd4, 1'b1, 1'b0},
    {2'd0, 8'd5,  8'hEF, 3'd5, 1'b1, 1'b0},
    {2'd0, 8'd5,  8'hCF, 3'd4, 1'b1, 1'b1},
    {2'd1, 8'd3,  8'hFF, 3'd7, 1'b1, 1'b0},
    {2'd2, 8'd0,  8'hFB, 3'd6, 1'b1, 1'b0},
    {2'd0, 8'd9,  8'hFF, 3'd4, 1'b1, 1'b0},
    {2'd0, 8'd20, 8'hFF, 3'd2, 1'b0, 1'b0},
    {2'd0, 8'd20, 8'hFF, 3'd2, 1'b1, 1'b0},
    {2'd1, 8'd20, 8'hFF, 3'd3, 1'b0, 1'b0},
    {2'd0, 8'd21, 8'hFF, 3'd4, 1'b0, 1'b0},
    {2'd0, 8'd21, 8'hEF, 3'd4, 1'b0, 1'b1},
    {2'd1, 8'd20, 8'hFF, 3'd3, 1'b1, 1'b0},
    {2'd0, 8'd20, 8'hFB, 3'd2, 1'b1, 1'b1}
  };
  string vreq [NV] = '{"R3", "R3", "R4", "R2", "R3", "R5", "R6", "R9",
                       "R2", "R8", "R8", "R2", "R4"};

  task automatic check(input string req, input logic [4:0] act, input logic [4:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: {core,hit,wait} actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic config_wr(input logic [1:0] c, input logic [7:0] n, input logic [7:0] m);
    cfg_we = 1; cfg_class = c; cfg_num = n; cfg_mask = m;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic lookup(input logic [1:0] c, input logic [7:0] n, input logic [7:0] f,
                        input logic [2:0] ec, input logic eh, input logic ew, input string req);
    lk_valid = 1; lk_class = c; lk_num = n; ctx_free = f;
    @(negedge clk);
    tests++;
    if (rsp_valid !== 1'b1) begin
      fails++;
      $display("FAIL R9: rsp_valid actual %b expected 1", rsp_valid);
    end
    check(req, {rsp_core, rsp_hit, rsp_wait}, {ec, eh, ew});
  endtask

  task automatic do_reset;
    lk_valid = 0; cfg_we = 0; rst_n = 0;
    @(negedge clk); @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    #(20 * 5000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0;
    @(negedge clk); @(negedge clk);
    tests++;
    if (rsp_valid !== 1'b0) begin
      fails++;
      $display("FAIL R1: rsp_valid actual %b expected 0", rsp_valid);
    end
    rst_n = 1;

    config_wr(2'd0, 8'd5, 8'h30);
    config_wr(2'd1, 8'd3, 8'h80);
    config_wr(2'd2, 8'd0, 8'h44);
    config_wr(2'd0, 8'd9, 8'h10);   // R5: shares core 4 with key (0,5)

    for (int i = 0; i < NV; i++)
      lookup(VEC[i][22:21], VEC[i][20:13], VEC[i][12:5], VEC[i][4:2], VEC[i][1], VEC[i][0], vreq[i]);
    lk_valid = 0;
    @(negedge clk);

    // R10: overwrite an existing key while the table is full
    config_wr(2'd0, 8'd5, 8'h08);
    lookup(2'd0, 8'd5, 8'hFF, 3'd3, 1'b1, 1'b0, "R10");
    lk_valid = 0;

    // R1: fresh table, pointer back at start
    do_reset();
    lookup(2'd0, 8'd100, 8'hFF, 3'd2, 1'b0, 1'b0, "R1");
    for (int k = 1; k < 6; k++)
      lookup(2'd0, 8'(100 + k), 8'hFF, 3'(2 + k), 1'b0, 1'b0, "R7");
    // R7: wrap past user cores 0 and 1 back to core 2; R8: full, nothing stored
    lookup(2'd0, 8'd106, 8'hFF, 3'd2, 1'b0, 1'b0, "R7");
    lookup(2'd0, 8'd106, 8'hFF, 3'd2, 1'b0, 1'b0, "R8");
    lookup(2'd0, 8'd100, 8'hFF, 3'd2, 1'b1, 1'b0, "R6");
    lookup(2'd0, 8'd107, 8'hFB, 3'd2, 1'b0, 1'b1, "R6");
    lk_valid = 0;
    @(negedge clk);
    tests++;
    if (rsp_valid !== 1'b0) begin
      fails++;
      $display("FAIL R9: rsp_valid actual %b expected 0", rsp_valid);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule